// File: doc/BRIEF.md
# Serial EEPROM Boot Loader

This block fills a device's configuration register file from an external serial EEPROM over a two-wire bus, right after reset. It stays quiet until its active-low start input goes low. It then takes the bus as master and reads a fixed-size block of configuration bytes. The region it reads is chosen by a 2-bit strap. Each byte is passed to a register-file write port together with a per-register mask of loadable bits. When the block has been read cleanly, it releases the bus, drives its active-low done output low and reports that the device may now act as a bus slave.

Several loaders can share one EEPROM. The done output of one loader feeds the start input of the next, so only one of them masters the bus at a time. The first loader's start may be tied low so that loading begins as soon as reset ends. Both bus lines are open-drain. The block only pulls a line low or lets it go, and it reads back the clock line so that a slave holding the clock low stretches the bit. A missing acknowledge ends the load: the block lets go of both lines, keeps done high and raises an error flag.

Top module: `eeboot_loader`

## Requirements
- R1: After reset the block pulls neither line low, writes no register, and holds `done_n` high, `err` low and `slave_mode` low for as long as `start_n` stays high.
- R2: A load is one random-read transfer in this order: START, device byte with write (bit 0 = 0), low 8 bits of the word address, repeated START, device byte with read (bit 0 = 1). The device byte is 0xA0 with word-address bits [9:8] placed in bits [2:1].
- R3: The region starts at word address `BASE_ADDR + strap*REGION_BYTES`. With the default base of 0x0F0 and 8-byte regions, strap 2 starts at 0x100 and uses device byte 0xA2 and word byte 0x00.
- R4: After the final byte and STOP, `done_n` goes low and `slave_mode` goes high. Both lines stay released and `done_n` stays low until reset.
- R5: The master acknowledges every data byte except the last one, which it does not acknowledge. It then sends STOP.
- R6: Each received byte gives exactly one single-cycle `rf_we` pulse. `rf_addr` counts up from 0, `rf_wmask` equals `LOAD_MASK[8*rf_addr +: 8]`, and `rf_wdata` is the received byte ANDed with that mask, so bits that cannot be loaded are 0.
- R7: `own_addr` is the slave write address 0x30 + 2*strap: 0x30, 0x32, 0x34 or 0x36 for strap 0 to 3.
- R8: While a slave holds SCL low, the high phase of the bit does not begin. A load with a stretched clock still delivers the correct bytes.
- R9: A missing acknowledge on an address byte sets `err`, which stays set. Both lines are released, `done_n` stays high, and no further register writes follow.
- R10: When the clock is not stretched, each SCL high phase lasts 2*`QTR_CYC` clock cycles, within one cycle. A bit takes 4*`QTR_CYC` cycles; the default of 78 at 125 MHz gives about 400 kHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_n | input | 1 | Active-low start of the load (previous loader's done) |
| strap | input | 2 | Position in the chain; selects region and slave address |
| scl_i | input | 1 | Sensed level of the clock line |
| sda_i | input | 1 | Sensed level of the data line |
| scl_pull | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| done_n | output | 1 | Active-low: load finished successfully |
| err | output | 1 | Load aborted on a missing acknowledge |
| slave_mode | output | 1 | Bus handed back; device acts as slave |
| own_addr | output | 8 | Slave write address chosen by the strap |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | $clog2(REGION_BYTES) | Register index within the region |
| rf_wdata | output | 8 | Masked write data |
| rf_wmask | output | 8 | Loadable-bit mask for this register |

## Verification
A wrong sequencer state appears on the bus within one byte time. The EEPROM model would see a wrong device or word byte, a missing repeated START, a wrong acknowledge pattern or a missing STOP, or `done_n` would never fall. A wrong byte counter or mask selection appears as a write to the wrong index, as data bits leaking outside the mask, or as too many or too few writes by the time the load ends. Faults in the bit engine's phase timing appear as SCL high phases of the wrong length, or as lost bytes when the slave stretches the clock.

// File: rtl/eeboot_pkg.sv
// Shared types and constants for the serial EEPROM boot loader.
// Assumes a 10-bit EEPROM word address (at most 1024 bytes).
package eeboot_pkg;

    localparam int           EE_AW         = 10;
    localparam logic [7:0]   EE_DEV_BASE   = 8'hA0;
    localparam logic [7:0]   OWN_ADDR_BASE = 8'h30;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_DEVW, S_WADR, S_RSTA,
        S_DEVR, S_READ, S_STOP, S_DONE, S_FAIL
    } boot_state_t;

    typedef enum logic [1:0] {
        C_START, C_STOP, C_BIT
    } bus_cmd_t;

endpackage

// File: rtl/eeboot_bitio.sv
// Bit engine: runs one bus condition (START, STOP) or one data bit in
// four phases of QTR_CYC cycles each. Lines are open-drain: the outputs
// request a pull-low. Phase 1 (clock released) counts only while the
// sensed clock is high, so slave clock stretching lengthens the bit.
// Assumes go is presented only while busy is low.
module eeboot_bitio
    import eeboot_pkg::*;
#(
    parameter int QTR_CYC = 78
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go,
    input  bus_cmd_t cmd,
    input  logic     tx,
    input  logic     scl_i,
    input  logic     sda_i,
    output logic     busy,
    output logic     done,
    output logic     rx,
    output logic     scl_low,
    output logic     sda_low
);
    localparam int QW = $clog2(QTR_CYC + 1);

    logic [1:0]    phase;
    logic [QW-1:0] qcnt;
    bus_cmd_t      cmd_q;
    logic          tx_q;

    // Line pull pattern {scl_low, sda_low} for a command in a phase.
    function automatic logic [1:0] drive_for(bus_cmd_t c, logic [1:0] ph,
                                             logic t, logic scl_now);
        logic [1:0] r;
        case (c)
            C_START: case (ph)
                2'd0:    r = {scl_now, 1'b0};
                2'd1:    r = 2'b00;
                2'd2:    r = 2'b01;
                default: r = 2'b11;
            endcase
            C_STOP: case (ph)
                2'd0:    r = 2'b11;
                2'd1:    r = 2'b01;
                default: r = 2'b00;
            endcase
            default: r = {(ph == 2'd0) || (ph == 2'd3), ~t};
        endcase
        return r;
    endfunction

    // Phase sequencing, stretch-aware timing and data sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            phase   <= 2'd0;
            qcnt    <= '0;
            cmd_q   <= C_BIT;
            tx_q    <= 1'b1;
            rx      <= 1'b1;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy  <= 1'b1;
                    cmd_q <= cmd;
                    tx_q  <= tx;
                    phase <= 2'd0;
                    qcnt  <= '0;
                    {scl_low, sda_low} <= drive_for(cmd, 2'd0, tx, scl_low);
                end
            end else if (phase == 2'd1 && !scl_i) begin
                qcnt <= qcnt;
            end else if (qcnt == QW'(QTR_CYC - 1)) begin
                qcnt <= '0;
                if (phase == 2'd2) rx <= sda_i;
                if (phase == 2'd3) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    phase <= phase + 2'd1;
                    {scl_low, sda_low} <= drive_for(cmd_q, phase + 2'd1, tx_q, scl_low);
                end
            end else begin
                qcnt <= qcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/eeboot_region.sv
// Strap decoder: derives the region start address, the EEPROM device
// bytes (high word-address bits folded into bits [2:1]) and the
// device's own slave write address. Assumes BASE_ADDR is aligned to
// REGION_BYTES and REGION_BYTES divides 256, so a region never crosses
// a 256-byte page.
module eeboot_region
    import eeboot_pkg::*;
#(
    parameter int               REGION_BYTES = 8,
    parameter logic [EE_AW-1:0] BASE_ADDR    = 10'h0F0
) (
    input  logic [1:0]       strap,
    output logic [EE_AW-1:0] base_addr,
    output logic [7:0]       dev_wr,
    output logic [7:0]       dev_rd,
    output logic [7:0]       own_addr
);
    localparam logic [EE_AW-1:0] RB = EE_AW'(REGION_BYTES);

    // Address arithmetic from the strap.
    always_comb begin
        base_addr = BASE_ADDR + ({{(EE_AW-2){1'b0}}, strap} * RB);
        dev_wr    = EE_DEV_BASE | {5'd0, base_addr[9:8], 1'b0};
        dev_rd    = dev_wr | 8'h01;
        own_addr  = OWN_ADDR_BASE + {5'd0, strap, 1'b0};
    end

endmodule

// File: rtl/eeboot_loader.sv
// Boot loader top: waits for start_n low, reads REGION_BYTES bytes from
// the EEPROM with one random-read transfer, writes each through the
// register-file port under LOAD_MASK, then releases the bus and drives
// done_n low. A missing acknowledge aborts into a sticky error state.
// Assumes start_n may be asynchronous (it is synchronized here).
module eeboot_loader
    import eeboot_pkg::*;
#(
    parameter int                            QTR_CYC      = 78,
    parameter int                            REGION_BYTES = 8,
    parameter logic [EE_AW-1:0]              BASE_ADDR    = 10'h0F0,
    parameter logic [REGION_BYTES*8-1:0]     LOAD_MASK    = '1,
    localparam int                           REG_AW       = $clog2(REGION_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic [1:0]        strap,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              done_n,
    output logic              err,
    output logic              slave_mode,
    output logic [7:0]        own_addr,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_addr,
    output logic [7:0]        rf_wdata,
    output logic [7:0]        rf_wmask
);
    boot_state_t       state;
    logic [1:0]        start_sync;
    logic [7:0]        shreg;
    logic [3:0]        bitcnt;
    logic [REG_AW-1:0] idx;
    logic              last;
    logic              active;
    logic              eng_go, eng_busy, eng_done, eng_rx, eng_scl, eng_sda, eng_tx;
    bus_cmd_t          eng_cmd;
    logic [EE_AW-1:0]  base_addr;
    logic [7:0]        dev_wr, dev_rd;
    logic [7:0]        cur_mask;

    eeboot_region #(.REGION_BYTES(REGION_BYTES), .BASE_ADDR(BASE_ADDR)) u_region (
        .strap(strap), .base_addr(base_addr), .dev_wr(dev_wr),
        .dev_rd(dev_rd), .own_addr(own_addr)
    );

    eeboot_bitio #(.QTR_CYC(QTR_CYC)) u_bitio (
        .clk(clk), .rst_n(rst_n), .go(eng_go), .cmd(eng_cmd), .tx(eng_tx),
        .scl_i(scl_i), .sda_i(sda_i), .busy(eng_busy), .done(eng_done),
        .rx(eng_rx), .scl_low(eng_scl), .sda_low(eng_sda)
    );

    // Command selection and bit value for the engine.
    always_comb begin
        active   = !(state == S_IDLE || state == S_DONE || state == S_FAIL);
        last     = (idx == REG_AW'(REGION_BYTES - 1));
        eng_go   = active && !eng_busy && !eng_done;
        cur_mask = LOAD_MASK[idx*8 +: 8];
        case (state)
            S_START, S_RSTA: eng_cmd = C_START;
            S_STOP:          eng_cmd = C_STOP;
            default:         eng_cmd = C_BIT;
        endcase
        if (state == S_READ) eng_tx = bitcnt[3] ? last : 1'b1;
        else                 eng_tx = bitcnt[3] ? 1'b1 : shreg[7];
    end

    // Open-drain outputs, released at once on abort.
    assign scl_pull   = eng_scl & ~err;
    assign sda_pull   = eng_sda & ~err;
    assign slave_mode = (state == S_DONE);

    // Two-flop synchronizer for the start handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) start_sync <= 2'b11;
        else        start_sync <= {start_sync[0], start_n};
    end

    // Transfer sequencer, byte assembly and register-file writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            shreg    <= '0;
            bitcnt   <= '0;
            idx      <= '0;
            done_n   <= 1'b1;
            err      <= 1'b0;
            rf_we    <= 1'b0;
            rf_addr  <= '0;
            rf_wdata <= '0;
            rf_wmask <= '0;
        end else begin
            rf_we <= 1'b0;
            case (state)
                S_IDLE: if (!start_sync[1]) state <= S_START;
                S_START: if (eng_done) begin
                    state  <= S_DEVW;
                    shreg  <= dev_wr;
                    bitcnt <= '0;
                end
                S_DEVW, S_WADR, S_DEVR: if (eng_done) begin
                    if (!bitcnt[3]) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (eng_rx) begin
                        state <= S_FAIL;
                        err   <= 1'b1;
                    end else begin
                        bitcnt <= '0;
                        case (state)
                            S_DEVW: begin state <= S_WADR; shreg <= base_addr[7:0]; end
                            S_WADR: state <= S_RSTA;
                            default: begin state <= S_READ; idx <= '0; end
                        endcase
                    end
                end
                S_RSTA: if (eng_done) begin
                    state  <= S_DEVR;
                    shreg  <= dev_rd;
                    bitcnt <= '0;
                end
                S_READ: if (eng_done) begin
                    if (!bitcnt[3]) begin
                        shreg  <= {shreg[6:0], eng_rx};
                        bitcnt <= bitcnt + 4'd1;
                    end else begin
                        rf_we    <= 1'b1;
                        rf_addr  <= idx;
                        rf_wmask <= cur_mask;
                        rf_wdata <= shreg & cur_mask;
                        bitcnt   <= '0;
                        if (last) state <= S_STOP;
                        else      idx   <= idx + 1'b1;
                    end
                end
                S_STOP: if (eng_done) begin
                    state  <= S_DONE;
                    done_n <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/eeboot_chk.sv
// Property checker for the boot loader, attached by bind.
// Observes ports plus the sequencer's idle indication.
module eeboot_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       idle_st,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic       done_n,
    input logic       err,
    input logic       rf_we,
    input logic [7:0] rf_wdata,
    input logic [7:0] rf_wmask
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_st |-> (!scl_pull && !sda_pull && done_n && !rf_we));

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_n |=> !done_n);

    // R4
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_n |-> (!scl_pull && !sda_pull));

    // R9
    err_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!scl_pull && !sda_pull && done_n));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && !rf_we));

    // R6
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> ((rf_wdata & ~rf_wmask) == 8'h00));

    // R6
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |=> !rf_we);

endmodule

bind eeboot_loader eeboot_chk u_chk (
    .clk(clk), .rst_n(rst_n), .idle_st(state == eeboot_pkg::S_IDLE),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .done_n(done_n), .err(err),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_wmask(rf_wmask)
);

// File: tb/eeboot_loader_bench.sv
// Directed bench for the boot loader with a behavioural EEPROM slave on
// wired-AND bus lines.
module eeboot_loader_bench;
    localparam int          Q    = 4;
    localparam int          NB   = 8;
    localparam logic [9:0]  BASE = 10'h0F0;
    localparam logic [63:0] MASK = 64'hFF7F_0FFF_F0FF_3CFF;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_n = 1'b1;
    logic [1:0] strap = 2'd0;
    logic       scl_pull, sda_pull, done_n, err, slave_mode, rf_we;
    logic [7:0] own_addr, rf_wdata, rf_wmask;
    logic [2:0] rf_addr;
    logic       s_scl = 1'b0, s_sda = 1'b0;
    wire        scl = ~(scl_pull | s_scl);
    wire        sda = ~(sda_pull | s_sda);

    int checks = 0, failures = 0, cycles = 0;

    always #4 clk = ~clk;

    eeboot_loader #(.QTR_CYC(Q), .REGION_BYTES(NB), .BASE_ADDR(BASE), .LOAD_MASK(MASK))
    u_eeboot_loader (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .strap(strap),
        .scl_i(scl), .sda_i(sda), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .done_n(done_n), .err(err), .slave_mode(slave_mode), .own_addr(own_addr),
        .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_wmask(rf_wmask)
    );

    function automatic logic [7:0] ee_byte(input logic [9:0] a);
        logic [7:0] v;
        v = a[7:0] * 8'd7;
        return (v + 8'h3) ^ {a[9:8], 6'd0};
    endfunction

    // write log
    int         wr_total = 0;
    logic [7:0] wr_data [64];
    logic [7:0] wr_mask [64];
    logic [2:0] wr_addr [64];
    always @(negedge clk) if (rst_n && rf_we) begin
        wr_data[wr_total % 64] = rf_wdata;
        wr_mask[wr_total % 64] = rf_wmask;
        wr_addr[wr_total % 64] = rf_addr;
        wr_total++;
    end

    // STOP conditions and SCL high-phase lengths
    int stop_cnt = 0, hi_run = 0, hi_good = 0, hi_bad = 0, pull_cnt = 0;
    always @(posedge sda) if (scl === 1'b1) stop_cnt++;
    always @(posedge clk) begin
        if (scl) hi_run++;
        else begin
            if (hi_run > 0 && hi_run < 100) begin
                if (hi_run >= 2*Q-1 && hi_run <= 2*Q+1) hi_good++;
                else hi_bad++;
            end
            hi_run = 0;
        end
    end
    always @(negedge clk) if (scl_pull || sda_pull) pull_cnt++;

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // EEPROM slave model
    int         stretch_cyc = 0;
    logic       force_nack = 1'b0;
    logic [7:0] rec_devw = 0, rec_waddr = 0, rec_devr = 0;
    int         m_acks = 0, m_nacks = 0;
    logic [9:0] ptr = 0;

    task automatic rx_byte(output logic [7:0] b);
        for (int i = 0; i < 8; i++) begin
            @(posedge scl);
            b = {b[6:0], sda};
        end
    endtask

    initial begin : slave
        logic [7:0] b, d;
        logic       mack;
        forever begin
            forever begin
                @(negedge sda);
                if (scl === 1'b1) break;
            end
            rx_byte(b);
            @(negedge scl);
            if (b[7:4] != 4'hA || force_nack) continue;
            s_sda = 1'b1;
            @(negedge scl);
            s_sda = 1'b0;
            if (!b[0]) begin
                rec_devw = b;
                rx_byte(d);
                @(negedge scl);
                s_sda = 1'b1;
                @(negedge scl);
                s_sda = 1'b0;
                rec_waddr = d;
                ptr = {b[2:1], d};
            end else begin
                rec_devr = b;
                if (stretch_cyc > 0) begin
                    s_scl = 1'b1;
                    repeat (stretch_cyc) @(posedge clk);
                    s_scl = 1'b0;
                end
                forever begin
                    d = ee_byte(ptr);
                    ptr = ptr + 10'd1;
                    for (int k = 7; k >= 0; k--) begin
                        s_sda = ~d[k];
                        @(negedge scl);
                    end
                    s_sda = 1'b0;
                    @(posedge scl);
                    mack = sda;
                    @(negedge scl);
                    if (mack) begin m_nacks++; break; end
                    m_acks++;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(negedge clk);
        rst_n = 1'b0; start_n = 1'b1; strap = s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_end();
        int n = 0;
        while (done_n && !err && n < 20000) begin @(posedge clk); n++; end
        @(negedge clk);
    endtask

    // R1: quiet until start
    task automatic idle_case();
        int p0, w0;
        do_reset(2'd0);
        p0 = pull_cnt; w0 = wr_total;
        chk("R1", "done_n after reset", done_n, 1);
        chk("R1", "err after reset", err, 0);
        chk("R1", "slave_mode after reset", slave_mode, 0);
        repeat (300) @(negedge clk);
        chk("R1", "pull cycles while start_n high", pull_cnt - p0, 0);
        chk("R1", "writes while start_n high", wr_total - w0, 0);
        chk("R1", "done_n still high", done_n, 1);
    endtask

    // R7: strap to own slave address
    task automatic own_addr_case();
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            @(negedge clk);
            chk("R7", "own_addr", own_addr, 8'h30 + 2*s);
        end
    endtask

    // R2-R6, R8, R10: successful load
    task automatic load_case(input logic [1:0] s, input int stretch);
        int w0, st0, a0, n0, hb0, hg0, p0;
        logic [9:0] base;
        logic [7:0] m;
        base = BASE + 10'(s) * 10'(NB);
        stretch_cyc = stretch; force_nack = 1'b0;
        do_reset(s);
        w0 = wr_total; st0 = stop_cnt; a0 = m_acks; n0 = m_nacks;
        hb0 = hi_bad; hg0 = hi_good;
        @(negedge clk) start_n = 1'b0;
        wait_end();
        chk("R2", "device write byte", rec_devw, 8'hA0 | (int'(base[9:8]) << 1));
        chk("R3", "word address byte", rec_waddr, base[7:0]);
        chk("R2", "device read byte", rec_devr, 8'hA1 | (int'(base[9:8]) << 1));
        chk("R6", "write count", wr_total - w0, NB);
        for (int i = 0; i < NB; i++) begin
            m = MASK[i*8 +: 8];
            chk("R6", "rf_addr", wr_addr[(w0+i)%64], i);
            chk("R6", "rf_wmask", wr_mask[(w0+i)%64], m);
            chk(stretch > 0 ? "R8" : "R6", "rf_wdata", wr_data[(w0+i)%64],
                ee_byte(base + 10'(i)) & m);
        end
        chk("R5", "master acks", m_acks - a0, NB - 1);
        chk("R5", "master final nack", m_nacks - n0, 1);
        chk("R5", "stop count", stop_cnt - st0, 1);
        chk("R4", "done_n low", done_n, 0);
        chk("R4", "slave_mode", slave_mode, 1);
        chk("R4", "err low", err, 0);
        if (stretch == 0) begin
            chk("R10", "bad scl high phases", hi_bad - hb0, 0);
            chk("R10", "scl high phases seen", (hi_good - hg0) > 90, 1);
        end
        p0 = pull_cnt;
        repeat (300) @(negedge clk);
        chk("R4", "pull cycles after done", pull_cnt - p0, 0);
        chk("R4", "done_n held", done_n, 0);
    endtask

    // R9: device does not acknowledge
    task automatic nack_case();
        int w0, p0;
        stretch_cyc = 0; force_nack = 1'b1;
        do_reset(2'd1);
        w0 = wr_total;
        @(negedge clk) start_n = 1'b0;
        wait_end();
        chk("R9", "err set", err, 1);
        chk("R9", "done_n high", done_n, 1);
        chk("R9", "slave_mode low", slave_mode, 0);
        p0 = pull_cnt;
        repeat (300) @(negedge clk);
        chk("R9", "pull cycles after abort", pull_cnt - p0, 0);
        chk("R9", "writes after abort", wr_total - w0, 0);
        chk("R9", "err sticky", err, 1);
        force_nack = 1'b0;
    endtask

    initial begin
        idle_case();
        own_addr_case();
        load_case(2'd0, 0);
        load_case(2'd2, 0);
        load_case(2'd3, 60);
        nack_case();
        load_case(2'd1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule